// File: doc/BRIEF.md
# SPI Serial Clock Baud Generator

This block derives the SPI serial clock from the bus clock through two divide stages. A 2-bit index picks an odd-or-even prescale value. A 4-bit index picks a scale value from a table that is almost a power-of-two ladder, but index 2 gives 6. A double-rate input halves the combined ratio. The serial clock idles low. Each period starts with its low phase and ends with its high phase.

Beside the clock level, the block gives two one-cycle strobes. One marks each rising (leading) edge and the other marks each falling (trailing) edge, so a shift register can launch and capture data without edge-detecting the clock itself. While the enable input is low, the block holds everything cleared. A new divider selection is picked up only when a full period completes.

Top module: `spi_sck_baud_gen`

## Requirements
- R1: Prescale index values 0, 1, 2 and 3 select divide values 2, 3, 5 and 7 respectively.
- R2: Scale index k selects 2, 4 or 6 for k = 0, 1 or 2, and selects 2^k for k from 3 to 15.
- R3: With double-rate low, the serial clock period is N = prescale × scale bus cycles, with equal high and low phases of N/2 cycles.
- R4: With double-rate high, N = prescale × scale / 2. The high phase lasts floor(N/2) cycles and the low phase lasts N − floor(N/2) cycles, so for odd N the low phase is one cycle longer.
- R5: The clock is sampled once per bus cycle, counting k = 1 at the first sample after the first enabled edge. Let L be the low-phase length. Then sck_o is 1 exactly when (k mod N) ≥ L.
- R6: lead_o is high for one cycle, in the cycle where sck_o has just gone from 0 to 1. trail_o is high for one cycle, in the cycle where sck_o has just gone from 1 to 0 (k mod N = 0, k > 0).
- R7: A clock edge with en_i low makes sck_o, lead_o and trail_o 0 and clears the phase counter, so re-enabling restarts the R5 pattern from k = 1. No trailing strobe is given when the clock is cut short this way.
- R8: A change of the index or double-rate inputs while enabled leaves the current period unchanged. The new ratio applies from the period that starts after the next trailing strobe.
- R9: While rst_ni is low, sck_o, lead_o and trail_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Run enable; low holds the generator idle and cleared |
| presc_idx_i | input | 2 | Prescale index |
| scale_idx_i | input | 4 | Scale index |
| dbl_rate_i | input | 1 | Double-rate select, halves the total ratio |
| sck_o | output | 1 | Serial clock level |
| lead_o | output | 1 | One-cycle strobe on each rising SCK edge |
| trail_o | output | 1 | One-cycle strobe on each falling SCK edge |

## Verification
If the phase counter or the latched period is wrong, the level sequence at sck_o drifts away from the position formula. This shows within one serial clock period of the fault, as a misplaced edge or strobe. A divider change that is taken up too early shows as a shortened or stretched period before the next trailing strobe. A counter that is not cleared on disable shows as a wrong first rising edge after re-enable. Odd ratios in double-rate mode need their own trials, because they are the only cases where the high and low phases differ in length.

// File: rtl/spi_baud_pkg.sv
package spi_baud_pkg;
  localparam int unsigned PRESC_W = 2;
  localparam int unsigned SCALE_W = 4;
  // widest ratio: 7 * 2^(2^SCALE_W - 1)
  localparam int unsigned CNT_W   = 3 + (1 << SCALE_W) - 1;

  function automatic int unsigned presc_value(input logic [PRESC_W-1:0] idx);
    case (idx)
      2'd0:    return 2;
      2'd1:    return 3;
      2'd2:    return 5;
      default: return 7;
    endcase
  endfunction

  function automatic int unsigned scale_value(input logic [SCALE_W-1:0] idx);
    if (idx < 3) return 2 * (int'(idx) + 1);
    return 1 << idx;
  endfunction
endpackage

// File: rtl/sck_div_decode.sv
module sck_div_decode
  import spi_baud_pkg::*;
#(
  parameter int unsigned CW = CNT_W
) (
  input  logic [PRESC_W-1:0] presc_idx_i,
  input  logic [SCALE_W-1:0] scale_idx_i,
  input  logic               dbl_rate_i,
  output logic [CW-1:0]      period_o,
  output logic [CW-1:0]      low_len_o
);
  logic [CW-1:0] prod;

  always_comb begin
    prod      = CW'(presc_value(presc_idx_i) * scale_value(scale_idx_i));
    period_o  = dbl_rate_i ? (prod >> 1) : prod;
    // odd period: extra cycle goes to the low phase
    low_len_o = period_o - (period_o >> 1);
  end
endmodule

// File: rtl/sck_phase_gen.sv
module sck_phase_gen #(
  parameter int unsigned CW = 18
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic [CW-1:0] period_i,
  input  logic [CW-1:0] low_len_i,
  output logic          sck_o,
  output logic          lead_o,
  output logic          trail_o
);
  logic [CW-1:0] cnt_q, cur_n_q, cur_l_q;
  logic          sck_q, lead_q, trail_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      cur_n_q <= CW'(2);
      cur_l_q <= CW'(1);
      sck_q   <= 1'b0;
      lead_q  <= 1'b0;
      trail_q <= 1'b0;
    end else if (!en_i) begin
      cnt_q   <= '0;
      cur_n_q <= period_i;
      cur_l_q <= low_len_i;
      sck_q   <= 1'b0;
      lead_q  <= 1'b0;
      trail_q <= 1'b0;
    end else begin
      lead_q  <= 1'b0;
      trail_q <= 1'b0;
      if (cnt_q == cur_n_q - 1'b1) begin
        cnt_q   <= '0;
        cur_n_q <= period_i;   // period boundary: take new ratio
        cur_l_q <= low_len_i;
        sck_q   <= 1'b0;
        trail_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == cur_l_q - 1'b1) begin
          sck_q  <= 1'b1;
          lead_q <= 1'b1;
        end
      end
    end
  end

  assign sck_o   = sck_q;
  assign lead_o  = lead_q;
  assign trail_o = trail_q;

  assert_lead_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lead_q |=> !lead_q);
  assert_trail_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trail_q |=> !trail_q);
  assert_rise_has_lead_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sck_q) |-> lead_q);
  assert_fall_enabled_trail_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(sck_q) && $past(en_i)) |-> trail_q);
  assert_idle_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!sck_q && !lead_q && !trail_q && cnt_q == '0));
  assert_cnt_range_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < cur_n_q);
  assert_cfg_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != '0) |-> ($stable(cur_n_q) && $stable(cur_l_q)));
endmodule

// File: rtl/spi_sck_baud_gen.sv
module spi_sck_baud_gen
  import spi_baud_pkg::*;
#(
  parameter int unsigned CW = CNT_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic [PRESC_W-1:0] presc_idx_i,
  input  logic [SCALE_W-1:0] scale_idx_i,
  input  logic               dbl_rate_i,
  output logic               sck_o,
  output logic               lead_o,
  output logic               trail_o
);
  logic [CW-1:0] period, low_len;

  sck_div_decode #(.CW(CW)) u_decode (
    .presc_idx_i (presc_idx_i),
    .scale_idx_i (scale_idx_i),
    .dbl_rate_i  (dbl_rate_i),
    .period_o    (period),
    .low_len_o   (low_len)
  );

  sck_phase_gen #(.CW(CW)) u_phase (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (en_i),
    .period_i  (period),
    .low_len_i (low_len),
    .sck_o     (sck_o),
    .lead_o    (lead_o),
    .trail_o   (trail_o)
  );

  assert_phase_split_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (period >= CW'(2)) && (low_len >= period - low_len)
    && (low_len - (period - low_len) <= CW'(1)));
  assert_reset_idle_R9: assert property (@(posedge clk_i)
    !rst_ni |-> (!sck_o && !lead_o && !trail_o));
endmodule

// File: tb/spi_sck_baud_gen_tb_top.sv
module spi_sck_baud_gen_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic [1:0] p_idx = '0;
  logic [3:0] s_idx = '0;
  logic       dbl = 1'b0;
  logic       sck, lead, trail;
  int unsigned n_checks = 0;
  int unsigned n_errors = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  spi_sck_baud_gen dut_i (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en),
    .presc_idx_i(p_idx), .scale_idx_i(s_idx), .dbl_rate_i(dbl),
    .sck_o(sck), .lead_o(lead), .trail_o(trail)
  );

  function automatic int unsigned ref_presc(input int unsigned i);
    case (i)
      0: return 2;
      1: return 3;
      2: return 5;
      default: return 7;
    endcase
  endfunction

  function automatic int unsigned ref_scale(input int unsigned k);
    case (k)
      0: return 2;
      1: return 4;
      2: return 6;
      default: return 32'd1 << k;
    endcase
  endfunction

  function automatic int unsigned ref_period(input int unsigned p, input int unsigned s,
                                             input int unsigned d);
    int unsigned t;
    t = ref_presc(p) * ref_scale(s);
    return (d != 0) ? t / 2 : t;
  endfunction

  task automatic check(input string tag, input bit ok, input string what,
                       input int unsigned act, input int unsigned exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // compare one sample against the position formula; returns 1 on match
  function automatic bit sample_ok(input int unsigned k, input int unsigned n);
    int unsigned m;
    int unsigned l;
    m = k % n;
    l = n - n / 2;
    return (sck == (m >= l)) && (lead == (m == l)) && (trail == (m == 0));
  endfunction

  task automatic set_cfg(input int unsigned p, input int unsigned s, input int unsigned d);
    p_idx = 2'(p);
    s_idx = 4'(s);
    dbl   = d[0];
  endtask

  task automatic run_trial(input string tag, input int unsigned p, input int unsigned s,
                           input int unsigned d, input int unsigned nsamp);
    int unsigned n;
    int unsigned bad;
    int unsigned first_bad;
    n = ref_period(p, s, d);
    @(negedge clk);
    en = 1'b0;
    set_cfg(p, s, d);
    repeat (3) @(negedge clk);
    en = 1'b1;
    bad = 0;
    first_bad = 0;
    for (int unsigned k = 1; k <= nsamp; k++) begin
      @(negedge clk);
      if (!sample_ok(k, n)) begin
        if (bad == 0) first_bad = k;
        bad++;
      end
    end
    check(tag, bad == 0, $sformatf("p=%0d s=%0d d=%0d N=%0d first bad sample", p, s, d, n),
          first_bad, 0);
  endtask

  task automatic run_change(input int unsigned pa, input int unsigned sa, input int unsigned da,
                            input int unsigned pb, input int unsigned sb, input int unsigned db);
    int unsigned na;
    int unsigned nb;
    int unsigned bad;
    na = ref_period(pa, sa, da);
    nb = ref_period(pb, sb, db);
    @(negedge clk);
    en = 1'b0;
    set_cfg(pa, sa, da);
    repeat (2) @(negedge clk);
    en = 1'b1;
    bad = 0;
    for (int unsigned k = 1; k <= 2 * na; k++) begin
      @(negedge clk);
      if (!sample_ok(k, na)) bad++;
      if (k == na + na / 2) set_cfg(pb, sb, db);  // mid second period
    end
    check("R8", bad == 0, "old ratio kept until boundary, mismatches", bad, 0);
    bad = 0;
    for (int unsigned j = 1; j <= 2 * nb; j++) begin
      @(negedge clk);
      if (!sample_ok(j, nb)) bad++;
    end
    check("R8", bad == 0, "new ratio after boundary, mismatches", bad, 0);
  endtask

  task automatic run_disable;
    int unsigned n;
    int unsigned bad;
    n = ref_period(1, 1, 0);  // 12
    @(negedge clk);
    en = 1'b0;
    set_cfg(1, 1, 0);
    repeat (2) @(negedge clk);
    en = 1'b1;
    for (int unsigned k = 1; k <= n - 2; k++) @(negedge clk);  // inside high phase
    check("R7", sck == 1'b1, "sck high before disable", sck, 1);
    en = 1'b0;
    @(negedge clk);
    check("R7", {sck, lead, trail} == 3'b000, "outputs after disable",
          {sck, lead, trail}, 0);
    en = 1'b1;
    bad = 0;
    for (int unsigned k = 1; k <= 2 * n; k++) begin
      @(negedge clk);
      if (!sample_ok(k, n)) bad++;
    end
    check("R7", bad == 0, "restart from cleared counter, mismatches", bad, 0);
  endtask

  initial begin
    void'($urandom(32'h5eed_c0de));
    set_cfg(0, 0, 0);
    repeat (3) @(negedge clk);
    check("R9", {sck, lead, trail} == 3'b000, "outputs in reset", {sck, lead, trail}, 0);
    en = 1'b1;
    @(negedge clk);
    check("R9", {sck, lead, trail} == 3'b000, "outputs in reset with enable",
          {sck, lead, trail}, 0);
    en = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    check("R9", {sck, lead, trail} == 3'b000, "outputs after reset", {sck, lead, trail}, 0);

    for (int unsigned p = 0; p < 4; p++) run_trial("R1", p, 1, 0, 2 * ref_period(p, 1, 0) + 2);
    for (int unsigned s = 0; s < 8; s++) run_trial("R2", 0, s, 0, 2 * ref_period(0, s, 0) + 2);
    run_trial("R4", 1, 0, 1, 10);   // N=3, low 2, high 1
    run_trial("R4", 0, 0, 1, 9);    // N=2
    run_trial("R4", 3, 0, 1, 22);   // N=7
    run_trial("R5", 2, 2, 0, 65);   // N=30
    run_trial("R6", 3, 3, 1, 60);   // N=28
    run_trial("R2", 3, 12, 0, ref_period(3, 12, 0) + 8);
    run_change(0, 1, 0, 3, 2, 1);
    run_change(1, 0, 1, 0, 3, 0);
    run_disable();

    for (int t = 0; t < 30; t++) begin
      int unsigned p;
      int unsigned s;
      int unsigned d;
      p = $urandom % 4;
      s = $urandom % 8;
      d = $urandom % 2;
      run_trial((d != 0) ? "R4" : "R3", p, s, d, 2 * ref_period(p, s, d) + 3);
    end
    done = 1'b1;
  end

  initial begin
    int unsigned cyc;
    cyc = 0;
    while (!done && cyc < 190000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    end
    $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule